// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block lets a processor drive an 8-bit NAND flash device one bus cycle at a time through a 32-bit register interface. A write to the command register produces a command-latch cycle and a write to the address register produces an address-latch cycle. A write or read of the data register produces a single data cycle, and on a read the captured flash byte comes back in the low byte of the read word. Every flash cycle walks through four phases in a fixed order: setup, strobe, hold and ready-wait. Each phase lasts a programmed number of clocks, taken from one packed timing register that holds separate settings for write-type cycles and read cycles.

The register bus is a simple select/strobe interface. A register access that starts a flash cycle is stalled until that cycle has finished, so the master holds its request while `regStall` is high and accesses can never overlap. Software can also force chip enable active, read the flash ready line, take sticky interrupt flags with a mask and write-one-to-clear, and issue a software reset.

Register select map (word index on `regSel`): 0 data, 1 command, 2 address, 3 control, 4 configuration, 5 status, 6 interrupt flags, 7 interrupt enable, 8 interrupt clear, 9 timing.

Top module: `nand_cycle_if`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high (inactive), the command-latch, address-latch and output-enable pins are low, `irq` is low and `regStall` is low.
- R2: Writing select 1 runs a write cycle that drives bits 7:0 of the written word on `flashDout`, with `flashCle` high and `flashAle` low while `flashWeN` is low.
- R3: Writing select 2 runs a write cycle that drives bits 7:0 of the written word on `flashDout`, with `flashAle` high and `flashCle` low while `flashWeN` is low.
- R4: Writing select 0 runs a write cycle that drives bits 7:0 on `flashDout` with both latch pins low. Reading select 0 runs a cycle that pulses `flashReN`, keeps `flashDoe` low, and returns the byte on `flashDin` at the last strobe clock in `regRdata[7:0]`, with bits 31:8 zero.
- R5: The timing register (select 9, read back as written) holds eight 4-bit counts. Bits 3:0 are read setup, 7:4 read hold, 11:8 read strobe width and 15:12 read ready-wait. Bits 19:16, 23:20, 27:24 and 31:28 hold the same four counts for write, command and address cycles. A phase lasts its count in clocks, and a count of 0 lasts 1 clock. Chip enable is low through all four phases.
- R6: Read cycles use only bits 15:0 of the timing register, and all other cycles use only bits 31:16.
- R7: While bit 5 of the configuration register (select 4) is 1, `flashCeN` is low. While it is 0, `flashCeN` is low only during a flash cycle.
- R8: Bit 0 of the status register (select 5) equals `flashRdy`.
- R9: Interrupt flag bit 0 sets on a rising edge of `flashRdy`, and bit 1 sets when a data cycle (select 0, read or write) completes. Writing 1s to select 8 clears the matching flags. `irq` is the OR of the flags ANDed with the enable register (select 7, same bit positions).
- R10: Writing the control register (select 3) with bit 2 set returns the cycle sequencer to idle and clears the configuration register.
- R11: For an access that starts a flash cycle, `regStall` stays high for 1 + setup + width + hold + ready-wait clocks, with each count taken as at least 1. Strobes are never active while `regStall` is low, the two strobes are never low together, and the two latch pins are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 4 | Register word select |
| regWr | input | 1 | Register write request, held while stalled |
| regRd | input | 1 | Register read request, held while stalled |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data |
| regStall | output | 1 | Access not yet complete |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashCle | output | 1 | Command-latch enable |
| flashAle | output | 1 | Address-latch enable |
| flashWeN | output | 1 | Write strobe, active low |
| flashReN | output | 1 | Read strobe, active low |
| flashDout | output | 8 | Byte driven toward the flash |
| flashDoe | output | 1 | Output enable for `flashDout` |
| flashDin | input | 8 | Byte from the flash |
| flashRdy | input | 1 | Flash ready (1) / busy (0) |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions check on every cycle that the strobe and latch pins are mutually exclusive, that chip enable covers every strobe, that output data stays stable during a write strobe, that no strobe is active once the stall has dropped, and that the status bit follows the ready line. The exact phase lengths come only from the bench's sweep over timing counts, which includes the zero-count case. The bench also shows which half of the timing register each cycle kind uses, the byte captured on reads, flag clearing and masking, and the effect of software reset.

// File: rtl/nand_cycle_pkg.sv
package nand_cycle_pkg;

  localparam int SEL_W = 4;

  localparam logic [SEL_W-1:0] SEL_DATA   = 4'd0;
  localparam logic [SEL_W-1:0] SEL_CMD    = 4'd1;
  localparam logic [SEL_W-1:0] SEL_ADDR   = 4'd2;
  localparam logic [SEL_W-1:0] SEL_CTRL   = 4'd3;
  localparam logic [SEL_W-1:0] SEL_CFG    = 4'd4;
  localparam logic [SEL_W-1:0] SEL_STATUS = 4'd5;
  localparam logic [SEL_W-1:0] SEL_IFLAG  = 4'd6;
  localparam logic [SEL_W-1:0] SEL_IEN    = 4'd7;
  localparam logic [SEL_W-1:0] SEL_ICLR   = 4'd8;
  localparam logic [SEL_W-1:0] SEL_TIMING = 4'd9;

  localparam int CFG_CE_FORCE_BIT = 5;
  localparam int CTRL_SWRST_BIT   = 2;
  localparam int IRQ_RDY_BIT      = 0;
  localparam int IRQ_DONE_BIT     = 1;
  localparam int IRQ_W            = 2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_RWAIT, PH_DONE
  } phase_e;

  typedef enum logic [1:0] {
    OP_CMD, OP_ADDR, OP_WDATA, OP_RDATA
  } op_e;

  typedef struct packed {
    logic idle;
    logic busy;
    logic strobeOn;
    logic capture;
    logic finish;
  } ctrl_strobes_t;

endpackage

// File: rtl/nand_cycle_ctrl.sv
module nand_cycle_ctrl
  import nand_cycle_pkg::*;
#(
  parameter int FIELD_W = 4,
  localparam int HALF_W = 4 * FIELD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReset,
  input  logic              launch,
  input  logic              isRead,
  input  logic [HALF_W-1:0] wrTiming,
  input  logic [HALF_W-1:0] rdTiming,
  output ctrl_strobes_t     strb
);

  // Sub-field order within each half: setup, hold, width, ready-wait
  localparam int F_SETUP = 0;
  localparam int F_HOLD  = 1;
  localparam int F_WIDTH = 2;
  localparam int F_RWAIT = 3;

  phase_e              phase;
  logic [FIELD_W-1:0]  cnt;
  logic [HALF_W-1:0]   tim;
  logic                rdKind;
  logic [HALF_W-1:0]   launchTim;

  function automatic logic [FIELD_W-1:0] lastCnt(input logic [FIELD_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  function automatic logic [FIELD_W-1:0] field(input logic [HALF_W-1:0] t, input int idx);
    return t[idx*FIELD_W +: FIELD_W];
  endfunction

  assign launchTim = isRead ? rdTiming : wrTiming;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      tim    <= '0;
      rdKind <= 1'b0;
    end else if (swReset) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (launch) begin
          phase  <= PH_SETUP;
          tim    <= launchTim;
          rdKind <= isRead;
          cnt    <= lastCnt(field(launchTim, F_SETUP));
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_STROBE;
          cnt   <= lastCnt(field(tim, F_WIDTH));
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt == '0) begin
          phase <= PH_HOLD;
          cnt   <= lastCnt(field(tim, F_HOLD));
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt == '0) begin
          phase <= PH_RWAIT;
          cnt   <= lastCnt(field(tim, F_RWAIT));
        end else cnt <= cnt - 1'b1;
        PH_RWAIT: if (cnt == '0) phase <= PH_DONE;
                  else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.idle     = (phase == PH_IDLE);
    strb.busy     = (phase == PH_SETUP) || (phase == PH_STROBE) ||
                    (phase == PH_HOLD)  || (phase == PH_RWAIT);
    strb.strobeOn = (phase == PH_STROBE);
    strb.capture  = (phase == PH_STROBE) && (cnt == '0) && rdKind;
    strb.finish   = (phase == PH_DONE);
  end

endmodule

// File: rtl/nand_cycle_dp.sv
module nand_cycle_dp
  import nand_cycle_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FLASH_W = 8,
  parameter int FIELD_W = 4,
  localparam int HALF_W = 4 * FIELD_W,
  localparam int TIM_W  = 2 * HALF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   regSel,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               regStall,
  output logic               flashCeN,
  output logic               flashCle,
  output logic               flashAle,
  output logic               flashWeN,
  output logic               flashReN,
  output logic [FLASH_W-1:0] flashDout,
  output logic               flashDoe,
  input  logic [FLASH_W-1:0] flashDin,
  input  logic               flashRdy,
  output logic               irq,
  input  ctrl_strobes_t      strb,
  output logic               launch,
  output logic               isRead,
  output logic               swReset,
  output logic [HALF_W-1:0]  wrTiming,
  output logic [HALF_W-1:0]  rdTiming
);

  logic [DATA_W-1:0]  cfgReg;
  logic [TIM_W-1:0]   timReg;
  logic [IRQ_W-1:0]   irqFlag;
  logic [IRQ_W-1:0]   irqEn;
  logic [IRQ_W-1:0]   setMask;
  logic [IRQ_W-1:0]   clrMask;
  logic [FLASH_W-1:0] byteQ;
  logic [FLASH_W-1:0] rdByte;
  op_e                opQ;
  op_e                opNow;
  logic               rdyQ;
  logic               flashReq;

  function automatic logic wrTo(input logic wr, input logic [SEL_W-1:0] s, input logic [SEL_W-1:0] t);
    return wr && (s == t);
  endfunction

  always_comb begin
    flashReq = wrTo(regWr, regSel, SEL_DATA) || wrTo(regWr, regSel, SEL_CMD) ||
               wrTo(regWr, regSel, SEL_ADDR) || wrTo(regRd, regSel, SEL_DATA);
    case (regSel)
      SEL_CMD:  opNow = OP_CMD;
      SEL_ADDR: opNow = OP_ADDR;
      default:  opNow = regRd ? OP_RDATA : OP_WDATA;
    endcase
  end

  assign launch   = flashReq && strb.idle;
  assign isRead   = (opNow == OP_RDATA);
  assign regStall = flashReq && !strb.finish;
  assign swReset  = wrTo(regWr, regSel, SEL_CTRL) && regWdata[CTRL_SWRST_BIT];
  assign wrTiming = timReg[TIM_W-1:HALF_W];
  assign rdTiming = timReg[HALF_W-1:0];

  always_comb begin
    setMask = '0;
    setMask[IRQ_RDY_BIT]  = flashRdy && !rdyQ;
    setMask[IRQ_DONE_BIT] = strb.finish && ((opQ == OP_WDATA) || (opQ == OP_RDATA));
    clrMask = wrTo(regWr, regSel, SEL_ICLR) ? regWdata[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg  <= '0;
      timReg  <= '0;
      irqFlag <= '0;
      irqEn   <= '0;
      byteQ   <= '0;
      rdByte  <= '0;
      opQ     <= OP_CMD;
      rdyQ    <= 1'b1;
    end else begin
      rdyQ    <= flashRdy;
      irqFlag <= (irqFlag & ~clrMask) | setMask;
      if (swReset) cfgReg <= '0;
      else if (wrTo(regWr, regSel, SEL_CFG)) cfgReg <= regWdata;
      if (wrTo(regWr, regSel, SEL_TIMING)) timReg <= regWdata[TIM_W-1:0];
      if (wrTo(regWr, regSel, SEL_IEN)) irqEn <= regWdata[IRQ_W-1:0];
      if (launch) begin
        opQ   <= opNow;
        byteQ <= regWdata[FLASH_W-1:0];
      end
      if (strb.capture) rdByte <= flashDin;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regSel)
      SEL_DATA:   regRdata[FLASH_W-1:0] = rdByte;
      SEL_CFG:    regRdata = cfgReg;
      SEL_STATUS: regRdata[0] = flashRdy;
      SEL_IFLAG:  regRdata[IRQ_W-1:0] = irqFlag;
      SEL_IEN:    regRdata[IRQ_W-1:0] = irqEn;
      SEL_TIMING: regRdata[TIM_W-1:0] = timReg;
      default:    regRdata = '0;
    endcase
  end

  assign flashCeN  = !(cfgReg[CFG_CE_FORCE_BIT] || strb.busy);
  assign flashCle  = strb.busy && (opQ == OP_CMD);
  assign flashAle  = strb.busy && (opQ == OP_ADDR);
  assign flashDoe  = strb.busy && (opQ != OP_RDATA);
  assign flashDout = byteQ;
  assign flashWeN  = !(strb.strobeOn && (opQ != OP_RDATA));
  assign flashReN  = !(strb.strobeOn && (opQ == OP_RDATA));
  assign irq       = |(irqFlag & irqEn);

endmodule

// File: rtl/nand_cycle_if.sv
module nand_cycle_if
  import nand_cycle_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FLASH_W = 8,
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   regSel,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               regStall,
  output logic               flashCeN,
  output logic               flashCle,
  output logic               flashAle,
  output logic               flashWeN,
  output logic               flashReN,
  output logic [FLASH_W-1:0] flashDout,
  output logic               flashDoe,
  input  logic [FLASH_W-1:0] flashDin,
  input  logic               flashRdy,
  output logic               irq
);

  localparam int HALF_W = 4 * FIELD_W;

  ctrl_strobes_t     strb;
  logic              launch;
  logic              isRead;
  logic              swReset;
  logic [HALF_W-1:0] wrTiming;
  logic [HALF_W-1:0] rdTiming;

  nand_cycle_ctrl #(.FIELD_W(FIELD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .swReset(swReset), .launch(launch),
    .isRead(isRead), .wrTiming(wrTiming), .rdTiming(rdTiming), .strb(strb)
  );

  nand_cycle_dp #(.DATA_W(DATA_W), .FLASH_W(FLASH_W), .FIELD_W(FIELD_W)) dp_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .regStall(regStall),
    .flashCeN(flashCeN), .flashCle(flashCle), .flashAle(flashAle),
    .flashWeN(flashWeN), .flashReN(flashReN), .flashDout(flashDout),
    .flashDoe(flashDoe), .flashDin(flashDin), .flashRdy(flashRdy), .irq(irq),
    .strb(strb), .launch(launch), .isRead(isRead), .swReset(swReset),
    .wrTiming(wrTiming), .rdTiming(rdTiming)
  );

endmodule

// File: rtl/nand_cycle_if_chk.sv
module nand_cycle_if_chk
  import nand_cycle_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FLASH_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [SEL_W-1:0]   regSel,
  input logic               regRd,
  input logic [DATA_W-1:0]  regRdata,
  input logic               regStall,
  input logic               flashCeN,
  input logic               flashCle,
  input logic               flashAle,
  input logic               flashWeN,
  input logic               flashReN,
  input logic [FLASH_W-1:0] flashDout,
  input logic               flashDoe,
  input logic               flashRdy
);

  assert_latch_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(flashCle && flashAle));

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashWeN && !flashReN));

  assert_no_strobe_unstalled_R11: assert property (@(posedge clk) disable iff (!rstN)
    !regStall |-> (flashWeN && flashReN));

  assert_ce_covers_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN || !flashReN) |-> !flashCeN);

  assert_read_no_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !flashReN |-> !flashDoe);

  assert_dout_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN && $past(rstN)) |-> $stable(flashDout));

  assert_status_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regSel == SEL_STATUS) |-> (regRdata[0] == flashRdy));

endmodule

bind nand_cycle_if nand_cycle_if_chk #(.DATA_W(DATA_W), .FLASH_W(FLASH_W)) chk_i (.*);

// File: tb/nand_cycle_if_tb_top.sv
module nand_cycle_if_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regSel = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regStall;
  logic        flashCeN, flashCle, flashAle, flashWeN, flashReN, flashDoe, irq;
  logic [7:0]  flashDout;
  logic [7:0]  flashDin = 8'h00;
  logic        flashRdy = 1'b1;

  int testCnt = 0;
  int failCnt = 0;

  int stallCnt, setupCnt, strobeCnt, tailCnt;
  logic cleS, aleS;
  logic [7:0] doutS;
  logic [31:0] rdVal;

  always #4 clk = ~clk;

  nand_cycle_if dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .regStall(regStall),
    .flashCeN(flashCeN), .flashCle(flashCle), .flashAle(flashAle),
    .flashWeN(flashWeN), .flashReN(flashReN), .flashDout(flashDout),
    .flashDoe(flashDoe), .flashDin(flashDin), .flashRdy(flashRdy), .irq(irq)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic access(input logic [3:0] sel, input logic wr, input logic [31:0] wd);
    bit seen;
    @(negedge clk);
    regSel = sel; regWr = wr; regRd = !wr; regWdata = wd;
    stallCnt = 0; setupCnt = 0; strobeCnt = 0; tailCnt = 0; seen = 0;
    cleS = 0; aleS = 0; doutS = 0;
    #1;
    while (regStall && stallCnt < 200) begin
      if (!flashWeN || !flashReN) begin
        strobeCnt++; seen = 1;
        cleS = flashCle; aleS = flashAle; doutS = flashDout;
      end else if (!flashCeN) begin
        if (seen) tailCnt++; else setupCnt++;
      end
      stallCnt++;
      @(negedge clk); #1;
    end
    rdVal = regRdata;
    @(negedge clk);
    regWr = 0; regRd = 0;
  endtask

  initial begin
    #(8 * 150000);
    failCnt++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    int vals[4] = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkEq("R1 ceN", flashCeN, 1);
    chkEq("R1 weN", flashWeN, 1);
    chkEq("R1 reN", flashReN, 1);
    chkEq("R1 cle", flashCle, 0);
    chkEq("R1 ale", flashAle, 0);
    chkEq("R1 doe", flashDoe, 0);
    chkEq("R1 irq", irq, 0);
    chkEq("R1 stall", regStall, 0);

    // R8 status follows ready line
    access(4'd5, 0, 0);
    chkEq("R8 ready", rdVal[0], 1);
    flashRdy = 0;
    access(4'd5, 0, 0);
    chkEq("R8 busy", rdVal[0], 0);
    flashRdy = 1;

    // Write-type sweep: write half varies, read half fixed at 7
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            int s = vals[a], w = vals[b], h = vals[c], r = vals[d];
            int k = a * 64 + b * 16 + c * 4 + d;
            logic [31:0] t;
            logic [3:0] sel;
            t = {r[3:0], w[3:0], h[3:0], s[3:0], 16'h7777};
            access(4'd9, 1, t);
            access(4'd9, 0, 0);
            chkEq("R5 timing readback", int'(rdVal), int'(t));
            sel = (k % 3 == 0) ? 4'd1 : ((k % 3 == 1) ? 4'd2 : 4'd0);
            access(sel, 1, 32'hABCD_0000 | k[7:0]);
            chkEq("R5 setup", setupCnt, eff(s));
            chkEq("R6 write width", strobeCnt, eff(w));
            chkEq("R5 hold+wait", tailCnt, eff(h) + eff(r));
            chkEq("R11 stall", stallCnt, 1 + eff(s) + eff(w) + eff(h) + eff(r));
            chkEq("R4 dout", doutS, k[7:0]);
            chkEq("R2 cle", cleS, sel == 4'd1);
            chkEq("R3 ale", aleS, sel == 4'd2);
          end

    // Read sweep: read half varies, write half fixed at 9
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            int s = vals[a], w = vals[b], h = vals[c], r = vals[d];
            int k = a * 64 + b * 16 + c * 4 + d;
            logic [7:0] fb;
            fb = k[7:0] ^ 8'hA5;
            access(4'd9, 1, {16'h9999, r[3:0], w[3:0], h[3:0], s[3:0]});
            flashDin = fb;
            access(4'd0, 0, 0);
            chkEq("R5 read setup", setupCnt, eff(s));
            chkEq("R6 read width", strobeCnt, eff(w));
            chkEq("R5 read hold+wait", tailCnt, eff(h) + eff(r));
            chkEq("R11 read stall", stallCnt, 1 + eff(s) + eff(w) + eff(h) + eff(r));
            chkEq("R4 read data", int'(rdVal), int'({24'h0, fb}));
          end

    // R7 forced chip enable
    access(4'd4, 1, 32'h20);
    chkEq("R7 forced", flashCeN, 0);
    access(4'd4, 1, 32'h0);
    chkEq("R7 released", flashCeN, 1);

    // R9 flags and mask
    access(4'd8, 1, 32'h3);
    access(4'd6, 0, 0);
    chkEq("R9 cleared", rdVal[1:0], 0);
    access(4'd7, 1, 32'h2);
    access(4'd0, 1, 32'h5A);
    access(4'd6, 0, 0);
    chkEq("R9 done flag", rdVal[1:0], 2);
    chkEq("R9 irq on", irq, 1);
    access(4'd8, 1, 32'h2);
    chkEq("R9 irq off", irq, 0);
    access(4'd1, 1, 32'h70);
    access(4'd6, 0, 0);
    chkEq("R9 cmd no flag", rdVal[1:0], 0);
    access(4'd7, 1, 32'h1);
    flashRdy = 0;
    repeat (2) @(negedge clk);
    chkEq("R9 no rdy event", irq, 0);
    flashRdy = 1;
    repeat (2) @(negedge clk);
    access(4'd6, 0, 0);
    chkEq("R9 rdy flag", rdVal[1:0], 1);
    chkEq("R9 rdy irq", irq, 1);
    access(4'd7, 1, 32'h0);
    chkEq("R9 masked", irq, 0);

    // R10 software reset
    access(4'd4, 1, 32'h20);
    access(4'd3, 1, 32'h4);
    access(4'd4, 0, 0);
    chkEq("R10 cfg cleared", int'(rdVal), 0);
    chkEq("R10 ce released", flashCeN, 1);
    access(4'd1, 1, 32'hFF);
    chkEq("R10 cycle after reset", doutS, 8'hFF);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule